// File: doc/BRIEF.md
# Four-Channel Serial DAC Register Controller

This block sits between a simple parallel register bus and a four-channel, 16-bit DAC that is loaded through a serial port. Software puts a 16-bit code in the data register. It then writes the channel-select register, which names one of four channels and an auto-load bit. That write sends a 24-bit serial frame carrying the channel address and the code into the chosen channel's holding register inside the DAC. All four analog outputs are moved from their holding registers by a single active-low load strobe. The strobe comes either at once, after the frame (auto-load set), or later, when software writes the load register.

Only one serial operation can be in flight at a time. While it runs, the busy bit in the status register reads 1. The bus has no back-pressure: the write strobe is always taken in the cycle it is presented. A channel-select or load write that arrives while busy is dropped and sets a sticky error bit. Software is expected to poll busy before issuing the next command. The data register is not guarded: it may be rewritten at any time, because the frame samples it when the command is accepted. A static range input is reported in the status register. It tells software whether codes are two's complement (bipolar range) or straight binary (unipolar range).

Top module: `dac_reg_ctrl`

## Requirements
- R1: After reset, channel-select, data and error all read 0, busy reads 0, `dac_cs_n` and `dac_ld_n` are 1 and `dac_sclk` is 0.
- R2: Register offsets on `bus_addr`: 0x1 channel select, read as {bit7 auto-load, bits 6..2 zero, bits 1..0 channel}; 0x3 status; 0x4 data, all 16 bits; 0x7 load, which reads 0. Byte registers take `bus_wdata[7:0]`, and bits 15..8 of their read value are 0.
- R3: An accepted channel-select write sends one frame with `dac_cs_n` held low. The frame is 24 bits, MSB first: bits 23..22 are the channel, bits 21..16 are 0, and bits 15..0 are the data register value. Each bit is driven while `dac_sclk` is high and is stable at its falling edge. One serial-clock period is 2*HALF_CLKS clock cycles.
- R4: Busy (status bit 0) reads 1 from the cycle after an accepted command until the operation ends. The frame alone lasts 48*HALF_CLKS cycles (96 by default). An auto-load pulse adds 4*HALF_CLKS cycles.
- R5: With auto-load 0, a frame issues no load pulse. With auto-load 1, exactly one `dac_ld_n` low pulse follows the frame. The pulse lasts two serial-clock periods (8 cycles by default), and `dac_ld_n` is never low while `dac_cs_n` is low.
- R6: A load-register write while idle issues one load pulse of two serial-clock periods and no frame. Busy stays 1 for the length of the pulse.
- R7: A channel-select or load write while busy is ignored: it sends no frame, issues no pulse and leaves the channel-select readback unchanged. It also sets the error bit (status bit 2).
- R8: The error bit stays set until any write to the status register, which clears it. Accepted commands do not clear it.
- R9: Status bit 1 follows `range_uni`: 0 means bipolar with two's complement codes, 1 means unipolar with straight binary codes. Status bits 15..3 read 0.
- R10: Rewriting the data register during a frame does not change the frame in flight. The data register keeps its value, so a later channel-select write with no new data write sends that same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken in the cycle it is high |
| bus_addr | input | 3 | Register offset for both read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| range_uni | input | 1 | Static range select: 1 unipolar, 0 bipolar |
| dac_sclk | output | 1 | Serial clock to the DAC, idle low |
| dac_sdo | output | 1 | Serial data to the DAC, MSB first |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_ld_n | output | 1 | Active-low simultaneous output update strobe |

## Verification
The embedded assertions check a set of rules on every cycle. A write presented while busy must leave the channel-select register unchanged and set the error bit. The error bit must persist until a status write clears it. The load strobe must never overlap an active frame, the frame select may only be low while busy, and serial data must not move while the serial clock is low inside a frame. The remaining behaviours need complete scenarios and are shown only by the bench. These are the bit-exact frame contents, busy lasting exactly the frame length with or without the load pulse, and the width of the load pulse. The bench also shows that a dropped command produces no second frame, and that the data register can be reused or rewritten in flight.

// File: rtl/dacrc_pkg.sv
package dacrc_pkg;
  // Register offsets; software decodes these, so they are fixed.
  localparam logic [2:0] OFS_CHSEL  = 3'h1;
  localparam logic [2:0] OFS_STATUS = 3'h3;
  localparam logic [2:0] OFS_DATA   = 3'h4;
  localparam logic [2:0] OFS_LOAD   = 3'h7;

  // Status bit positions.
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_RANGE = 1;
  localparam int unsigned ST_ERR   = 2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_LOAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dacrc_clkdiv.sv
module dacrc_clkdiv #(
  parameter int unsigned HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_CLKS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_CLKS);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(HALF_CLKS - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = run && (cnt_q == CW'(HALF_CLKS - 1));
    end
  endgenerate
endmodule

// File: rtl/dacrc_regs.sv
module dacrc_regs
  import dacrc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              range_uni,
  output logic              start,
  output logic              load_req,
  output logic [CH_W-1:0]   start_ch,
  output logic              start_al,
  output logic [DATA_W-1:0] data_q
);
  localparam logic [ADDR_W-1:0] A_CHSEL  = ADDR_W'(OFS_CHSEL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);

  logic [CH_W-1:0] ch_q;
  logic            al_q;
  logic            err_q;
  logic            wr_chsel, wr_status, wr_data, wr_load;

  assign wr_chsel  = bus_wr && (bus_addr == A_CHSEL);
  assign wr_status = bus_wr && (bus_addr == A_STATUS);
  assign wr_data   = bus_wr && (bus_addr == A_DATA);
  assign wr_load   = bus_wr && (bus_addr == A_LOAD);

  // Commands are taken only while the sequencer is idle.
  assign start    = wr_chsel && !busy;
  assign load_req = wr_load && !busy;
  assign start_ch = bus_wdata[CH_W-1:0];
  assign start_al = bus_wdata[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ch_q   <= '0;
      al_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_data) begin
        data_q <= bus_wdata;
      end
      if (start) begin
        ch_q <= bus_wdata[CH_W-1:0];
        al_q <= bus_wdata[BYTE_W-1];
      end
      if (wr_status) begin
        err_q <= 1'b0;
      end else if ((wr_chsel || wr_load) && busy) begin
        err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CHSEL: begin
        bus_rdata[BYTE_W-1] = al_q;
        bus_rdata[CH_W-1:0] = ch_q;
      end
      A_STATUS: begin
        bus_rdata[ST_BUSY]  = busy;
        bus_rdata[ST_RANGE] = range_uni;
        bus_rdata[ST_ERR]   = err_q;
      end
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_BUSY_CHSEL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_chsel && busy) |=> ($stable(ch_q) && $stable(al_q))); // R7
  AST_BUSY_WR_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_chsel || wr_load) && busy) |=> err_q); // R7
  AST_STATUS_WR_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> !err_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wr_status) |=> err_q); // R8
endmodule

// File: rtl/dacrc_sequencer.sv
module dacrc_sequencer
  import dacrc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CH_W       = 2,
  parameter int unsigned PAD_W      = 6,
  parameter int unsigned LOAD_SCLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  logic              start_al,
  input  logic [DATA_W-1:0] start_data,
  input  logic              load_req,
  input  logic              tick,
  output logic              run,
  output logic              busy,
  output logic              sclk,
  output logic              sdo,
  output logic              cs_n,
  output logic              ld_n
);
  localparam int unsigned FRAME_W   = CH_W + PAD_W + DATA_W;
  localparam int unsigned BIT_CW    = $clog2(FRAME_W);
  localparam int unsigned LD_HALVES = 2 * LOAD_SCLKS;
  localparam int unsigned LD_CW     = $clog2(LD_HALVES + 1);

  seq_state_e         state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [BIT_CW-1:0]  bit_q;
  logic [LD_CW-1:0]   ld_half_q;
  logic               al_q;
  logic               sclk_q, cs_n_q, ld_n_q;

  assign run  = (state_q != SQ_IDLE);
  assign busy = run;
  assign sclk = sclk_q;
  assign sdo  = shreg_q[FRAME_W-1];
  assign cs_n = cs_n_q;
  assign ld_n = ld_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      shreg_q   <= '0;
      bit_q     <= '0;
      ld_half_q <= '0;
      al_q      <= 1'b0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      ld_n_q    <= 1'b1;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_SHIFT;
            shreg_q <= {start_ch, {PAD_W{1'b0}}, start_data};
            bit_q   <= '0;
            al_q    <= start_al;
            sclk_q  <= 1'b1;
            cs_n_q  <= 1'b0;
          end else if (load_req) begin
            state_q   <= SQ_LOAD;
            ld_half_q <= '0;
            ld_n_q    <= 1'b0;
          end
        end
        SQ_SHIFT: begin
          if (tick) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else if (bit_q == BIT_CW'(FRAME_W - 1)) begin
              cs_n_q  <= 1'b1;
              shreg_q <= '0;
              if (al_q) begin
                state_q   <= SQ_LOAD;
                ld_half_q <= '0;
                ld_n_q    <= 1'b0;
              end else begin
                state_q <= SQ_IDLE;
              end
            end else begin
              sclk_q  <= 1'b1;
              shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
              bit_q   <= bit_q + 1'b1;
            end
          end
        end
        SQ_LOAD: begin
          if (tick) begin
            if (ld_half_q == LD_CW'(LD_HALVES - 1)) begin
              ld_n_q  <= 1'b1;
              state_q <= SQ_IDLE;
            end else begin
              ld_half_q <= ld_half_q + 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |-> cs_n); // R5
  AST_FRAME_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R4
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start || load_req) |-> !busy); // R7
  AST_SDO_HELD_LOW_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sclk) |=> (sclk || cs_n || $stable(sdo))); // R3
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dacrc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CH_W       = 2,
  parameter int unsigned PAD_W      = 6,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned HALF_CLKS  = 2,
  parameter int unsigned LOAD_SCLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              range_uni,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              dac_cs_n,
  output logic              dac_ld_n
);
  logic              busy, start, load_req, start_al, run, tick;
  logic [CH_W-1:0]   start_ch;
  logic [DATA_W-1:0] data_q;

  dacrc_regs #(
    .DATA_W(DATA_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .BYTE_W(8)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .range_uni(range_uni), .start(start), .load_req(load_req),
    .start_ch(start_ch), .start_al(start_al), .data_q(data_q)
  );

  dacrc_clkdiv #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dacrc_sequencer #(
    .DATA_W(DATA_W), .CH_W(CH_W), .PAD_W(PAD_W), .LOAD_SCLKS(LOAD_SCLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
    .start_al(start_al), .start_data(data_q), .load_req(load_req),
    .tick(tick), .run(run), .busy(busy), .sclk(dac_sclk), .sdo(dac_sdo),
    .cs_n(dac_cs_n), .ld_n(dac_ld_n)
  );
endmodule

// File: tb/tb_dac_reg_ctrl.sv
`timescale 1ns/1ps
module tb_dac_reg_ctrl;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 48 * HALF;
  localparam int LOAD_CYC = 4 * HALF;

  typedef struct packed {
    logic [1:0]  ch;
    logic        al;
    logic [15:0] data;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{2'd0, 1'b0, 16'hA5C3},
    '{2'd3, 1'b1, 16'h8000},
    '{2'd1, 1'b0, 16'hFFFF},
    '{2'd2, 1'b1, 16'h0001},
    '{2'd3, 1'b0, 16'h7FFF}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, range_uni = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic dac_sclk, dac_sdo, dac_cs_n, dac_ld_n;

  int checks = 0, errors = 0, cyc = 0;
  int nbits = 0, frames = 0, last_bits = 0, pulses = 0, ld_t0 = 0, ld_w = 0;
  bit overlap = 0;
  logic [23:0] sh = 0, last_frame = 0;

  always #5 clk = ~clk;

  dac_reg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .range_uni(range_uni),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .dac_cs_n(dac_cs_n), .dac_ld_n(dac_ld_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R4 watchdog expired act=%0d exp<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge dac_sclk) if (!dac_cs_n) begin sh = {sh[22:0], dac_sdo}; nbits++; end
  always @(posedge dac_cs_n) begin last_frame = sh; last_bits = nbits; nbits = 0; frames++; end
  always @(negedge dac_ld_n) begin ld_t0 = cyc; if (!dac_cs_n) overlap = 1; end
  always @(posedge dac_ld_n) if (rst_n) begin ld_w = cyc - ld_t0; pulses++; end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] s;
    n = 0;
    forever begin
      rd(3'h3, s);
      if (!s[0] || n > 5000) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] v;
    int n, f0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n idle", 32'(dac_cs_n), 1);
    chk("R1", "ld_n idle", 32'(dac_ld_n), 1);
    chk("R1", "sclk idle", 32'(dac_sclk), 0);
    rst_n = 1;
    @(negedge clk);
    rd(3'h1, v); chk("R1", "chsel reset", 32'(v), 0);
    rd(3'h4, v); chk("R1", "data reset", 32'(v), 0);
    rd(3'h3, v); chk("R1", "status reset", 32'(v), 0);
    rd(3'h7, v); chk("R2", "load reads 0", 32'(v), 0);
    rd(3'h0, v); chk("R2", "unmapped reads 0", 32'(v), 0);

    // R9 range flag
    range_uni = 1; rd(3'h3, v); chk("R9", "status unipolar", 32'(v), 32'h2);
    range_uni = 0; rd(3'h3, v); chk("R9", "status bipolar", 32'(v), 32'h0);

    // Vector table: R2 R3 R4 R5
    foreach (VECS[i]) begin
      f0 = frames; p0 = pulses;
      wr(3'h4, VECS[i].data);
      wr(3'h1, {8'hFF, VECS[i].al, 5'b11111, VECS[i].ch});
      wait_idle(n);
      chk("R4", "busy cycles", 32'(n), 32'(FRAME_CYC + (VECS[i].al ? LOAD_CYC : 0)));
      chk("R3", "frame count", 32'(frames - f0), 1);
      chk("R3", "frame bits", 32'(last_bits), 24);
      chk("R3", "frame content", 32'(last_frame), 32'({VECS[i].ch, 6'b0, VECS[i].data}));
      chk("R5", "load pulses", 32'(pulses - p0), VECS[i].al ? 1 : 0);
      if (VECS[i].al) chk("R5", "load width", 32'(ld_w), 32'(LOAD_CYC));
      rd(3'h1, v); chk("R2", "chsel readback", 32'(v), 32'({8'h0, VECS[i].al, 5'b0, VECS[i].ch}));
      rd(3'h4, v); chk("R2", "data readback", 32'(v), 32'(VECS[i].data));
    end
    chk("R5", "no load during frame", 32'(overlap), 0);

    // R6 load register alone
    f0 = frames; p0 = pulses;
    wr(3'h7, 16'h00FF);
    wait_idle(n);
    chk("R6", "load busy cycles", 32'(n), 32'(LOAD_CYC));
    chk("R6", "load pulse count", 32'(pulses - p0), 1);
    chk("R6", "load width", 32'(ld_w), 32'(LOAD_CYC));
    chk("R6", "no frame", 32'(frames - f0), 0);

    // R7 writes while busy are dropped; R10 data rewrite in flight
    f0 = frames; p0 = pulses;
    wr(3'h4, 16'h1234);
    wr(3'h1, 16'h0001);
    wr(3'h4, 16'hBEEF);
    wr(3'h1, 16'h0082);
    wr(3'h7, 16'h0000);
    rd(3'h3, v); chk("R7", "error set", 32'(v[2]), 1);
    wait_idle(n);
    chk("R7", "single frame", 32'(frames - f0), 1);
    chk("R10", "frame keeps old data", 32'(last_frame), 32'({2'd1, 6'b0, 16'h1234}));
    chk("R7", "no pulse", 32'(pulses - p0), 0);
    rd(3'h1, v); chk("R7", "chsel unchanged", 32'(v), 32'h0001);

    // R8 sticky error, R10 data reuse
    wr(3'h1, 16'h0002);
    wait_idle(n);
    chk("R10", "reused data", 32'(last_frame), 32'({2'd2, 6'b0, 16'hBEEF}));
    rd(3'h3, v); chk("R8", "error sticky", 32'(v[2]), 1);
    wr(3'h3, 16'h0000);
    rd(3'h3, v); chk("R8", "error cleared", 32'(v), 0);

    // R1 reset in mid-frame returns outputs to idle
    wr(3'h1, 16'h0083);
    repeat (10) @(negedge clk);
    rst_n = 0; #1;
    chk("R1", "cs_n after reset", 32'(dac_cs_n), 1);
    rd(3'h1, v); chk("R1", "chsel after reset", 32'(v), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    rd(3'h3, v); chk("R1", "status after reset", 32'(v), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule